// File: doc/BRIEF.md
# Two-Level Grouped Channel Arbiter

This block selects the next channel to be serviced out of a request vector that covers two groups of channels. A selection runs in two stages. The first stage picks one of the two groups. The second stage picks one channel inside that group. Each stage has its own policy bit, which chooses fixed priority or rotating (round-robin) service. The two policy bits are independent of each other. For the fixed group policy, each group has a programmable priority bit. The priority bits are held in a small register that is loaded with a strobe.

The surrounding engine raises `arb_go` for one cycle whenever it is ready to start a new channel. The registered grant appears on the next cycle as a one-cycle `gnt_valid` pulse, together with the winning group and the global channel index. The bits for group g occupy `req[g*CH_PER_GRP +: CH_PER_GRP]`. The global index is `g*CH_PER_GRP + local`. `CH_PER_GRP` must be a power of two and at least 2.

Top module: `grp_chan_arb`

## Requirements
- R1: After reset `gnt_valid` is 0. The group priority register holds 1 for group 1 and 0 for group 0. Both rotation pointers behave as if group 1 and local channel `CH_PER_GRP-1` won last.
- R2: A strobe at clock edge k with at least one request bit set gives `gnt_valid`=1 after edge k, for one cycle only. In that cycle `gnt_grp` is the group and `gnt_chan` is `gnt_grp*CH_PER_GRP + local index`. Without a strobe, `gnt_valid` is 0.
- R3: A strobe with an all-zero request vector gives no grant and leaves both rotation pointers unchanged.
- R4: A group that has no request bit set is never granted.
- R5: With `grp_rr_en`=0 and both groups requesting, the group with the higher priority bit wins. When the two priority bits are equal, group 1 wins.
- R6: With `grp_rr_en`=1 and both groups requesting, the group that did not win the previous grant wins.
- R7: With `chan_rr_en`=0, the highest-numbered requesting channel inside the chosen group wins.
- R8: With `chan_rr_en`=1, the search inside the chosen group starts one above that group's last winner and wraps around. Every grant records its winner as the new pointer for the group and for the winning group, whatever policy is in force.
- R9: A cycle with `prio_load`=1 writes `prio_in` into the priority register, with bit 0 for group 0 and bit 1 for group 1. The new values apply from the next strobe onward.
- R10: A change of either policy bit applies from the next strobe onward. Pointers are kept through periods without grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_go | input | 1 | Strobe that starts one arbitration |
| req | input | 2*CH_PER_GRP | Channel request vector, with group 0 in the low half |
| chan_rr_en | input | 1 | Channel-stage policy: 0 fixed, 1 round-robin |
| grp_rr_en | input | 1 | Group-stage policy: 0 fixed, 1 round-robin |
| prio_load | input | 1 | Load strobe for the group priority register |
| prio_in | input | 2 | New priorities, with bit 0 for group 0 and bit 1 for group 1 |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_grp | output | 1 | Winning group |
| gnt_chan | output | $clog2(2*CH_PER_GRP) | Global index of the winning channel |

## Verification
The assertions check every cycle for the following:
- a strobe with requests always gives a grant one cycle later, and a grant never appears otherwise;
- the pointers hold when there is no grant;
- a group without requests is never granted;
- a priority tie in fixed group mode goes to group 1;
- the group rotation alternates;
- the channel picked inside a group is always a requesting channel.

Some behaviour can only be shown by the bench scenarios. These are the exact rotation order across several grants, the correct handling of a priority load and of policy switches in the middle of a sequence, and the reset priority values. The bench shows these by comparing every cycle against a behavioural model, under directed and random traffic.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_GRP = 2;

    typedef enum logic {
        POL_FIXED = 1'b0,
        POL_RR    = 1'b1
    } policy_e;
endpackage

// File: rtl/chan_picker.sv
module chan_picker #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic          rr_en,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] idx
);
    import arb_pkg::*;

    policy_e pol;
    assign pol = policy_e'(rr_en);

    always_comb begin
        hit = |req;
        idx = '0;
        if (pol == POL_FIXED) begin
            // the last assignment wins, so the highest requester is kept
            for (int i = 0; i < N; i++) begin
                if (req[i]) idx = IW'(i);
            end
        end else begin
            // walk from the farthest slot back to the nearest, so the slot right after last wins
            for (int k = N; k >= 1; k--) begin
                if (req[IW'((int'(last) + k) % N)]) idx = IW'((int'(last) + k) % N);
            end
        end
    end

    // R7 / R8: the picked channel must be one that is requesting
    always_comb begin
        if (hit === 1'b1) begin
            a_r7_pick_is_requester: assert (req[idx] === 1'b1);
        end
    end
endmodule

// File: rtl/grp_picker.sv
module grp_picker (
    input  logic [1:0] any,
    input  logic       rr_en,
    input  logic       last_grp,
    input  logic [1:0] prio,
    output logic       hit,
    output logic       grp
);
    import arb_pkg::*;

    policy_e pol;
    assign pol = policy_e'(rr_en);

    always_comb begin
        hit = |any;
        if (any == 2'b11) begin
            if (pol == POL_RR) grp = ~last_grp;
            else               grp = (prio[0] & ~prio[1]) ? 1'b0 : 1'b1;
        end else begin
            grp = any[1];
        end
    end

    // R4: a group that is not requesting is never chosen
    always_comb begin
        if (hit === 1'b1) begin
            a_r4_grp_requesting: assert (any[grp] === 1'b1);
        end
    end
endmodule

// File: rtl/grp_chan_arb.sv
module grp_chan_arb #(
    parameter int CH_PER_GRP = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            arb_go,
    input  logic [2*CH_PER_GRP-1:0]         req,
    input  logic                            chan_rr_en,
    input  logic                            grp_rr_en,
    input  logic                            prio_load,
    input  logic [1:0]                      prio_in,
    output logic                            gnt_valid,
    output logic                            gnt_grp,
    output logic [$clog2(2*CH_PER_GRP)-1:0] gnt_chan
);
    import arb_pkg::*;

    localparam int IW = $clog2(CH_PER_GRP);
    localparam int GW = IW + 1;

    typedef struct packed {
        logic                       valid;
        logic                       grp;
        logic [GW-1:0]              chan;
        logic                       last_grp;
        logic [NUM_GRP-1:0][IW-1:0] last_chan;
        logic [NUM_GRP-1:0]         prio;
    } state_t;

    state_t q, d;

    logic [NUM_GRP-1:0]         g_any;
    logic [NUM_GRP-1:0][IW-1:0] g_idx;
    logic                       sel_hit;
    logic                       sel_grp;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_stage
        chan_picker #(.N(CH_PER_GRP), .IW(IW)) u_pick (
            .req   (req[g*CH_PER_GRP +: CH_PER_GRP]),
            .rr_en (chan_rr_en),
            .last  (q.last_chan[g]),
            .hit   (g_any[g]),
            .idx   (g_idx[g])
        );
    end

    grp_picker u_grp (
        .any      (g_any),
        .rr_en    (grp_rr_en),
        .last_grp (q.last_grp),
        .prio     (q.prio),
        .hit      (sel_hit),
        .grp      (sel_grp)
    );

    always_comb begin
        d = q;
        d.valid = 1'b0;
        if (prio_load) d.prio = prio_in;
        if (arb_go && sel_hit) begin
            d.valid              = 1'b1;
            d.grp                = sel_grp;
            d.chan               = {sel_grp, g_idx[sel_grp]};
            d.last_grp           = sel_grp;
            d.last_chan[sel_grp] = g_idx[sel_grp];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.valid     <= 1'b0;
            q.grp       <= 1'b0;
            q.chan      <= '0;
            q.last_grp  <= 1'b1;
            q.last_chan <= {NUM_GRP{IW'(CH_PER_GRP - 1)}};
            q.prio      <= 2'b10;
        end else begin
            q <= d;
        end
    end

    assign gnt_valid = q.valid;
    assign gnt_grp   = q.grp;
    assign gnt_chan  = q.chan;

    a_r2_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_go && (|req)) |=> gnt_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_go && (|req)) |=> !gnt_valid);
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_go && (|req)) |=> ($stable(q.last_grp) && $stable(q.last_chan)));
    a_r4_only_grp1: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_go && !(|req[CH_PER_GRP-1:0]) && (|req[2*CH_PER_GRP-1:CH_PER_GRP])) |=> (gnt_grp == 1'b1));
    a_r4_only_grp0: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_go && (|req[CH_PER_GRP-1:0]) && !(|req[2*CH_PER_GRP-1:CH_PER_GRP])) |=> (gnt_grp == 1'b0));
    a_r5_tie_to_grp1: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_go && !grp_rr_en && (|req[CH_PER_GRP-1:0]) && (|req[2*CH_PER_GRP-1:CH_PER_GRP])
         && (q.prio[0] == q.prio[1])) |=> (gnt_grp == 1'b1));
    a_r6_rr_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_go && grp_rr_en && (|req[CH_PER_GRP-1:0]) && (|req[2*CH_PER_GRP-1:CH_PER_GRP]))
        |=> (gnt_grp != $past(q.last_grp)));
endmodule

// File: tb/tb_grp_chan_arb.sv
module tb_grp_chan_arb;
    localparam int N  = 4;
    localparam int GW = $clog2(2*N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arb_go = 1'b0;
    logic [2*N-1:0] req = '0;
    logic          chan_rr_en = 1'b0;
    logic          grp_rr_en = 1'b0;
    logic          prio_load = 1'b0;
    logic [1:0]    prio_in = 2'b00;
    logic          gnt_valid;
    logic          gnt_grp;
    logic [GW-1:0] gnt_chan;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int ev = 0, eg = 0, ec = 0;
    int lg = 1;
    int lc [2];
    int pr0 = 0, pr1 = 1;

    grp_chan_arb #(.CH_PER_GRP(N)) dut (
        .clk(clk), .rst_n(rst_n), .arb_go(arb_go), .req(req),
        .chan_rr_en(chan_rr_en), .grp_rr_en(grp_rr_en),
        .prio_load(prio_load), .prio_in(prio_in),
        .gnt_valid(gnt_valid), .gnt_grp(gnt_grp), .gnt_chan(gnt_chan)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            ev = 0; eg = 0; ec = 0; lg = 1; lc[0] = N-1; lc[1] = N-1; pr0 = 0; pr1 = 1;
        end else begin
            bit a0, a1;
            int g, c;
            a0 = |req[N-1:0];
            a1 = |req[2*N-1:N];
            ev = 0;
            if (arb_go && (a0 || a1)) begin
                if (a0 && a1) g = grp_rr_en ? (lg == 0 ? 1 : 0) : (pr0 > pr1 ? 0 : 1);
                else          g = a1 ? 1 : 0;
                c = -1;
                if (!chan_rr_en) begin
                    for (int i = 0; i < N; i++) if (req[g*N+i]) c = i;
                end else begin
                    for (int k = 1; k <= N; k++)
                        if (c < 0 && req[g*N + (lc[g]+k)%N]) c = (lc[g]+k)%N;
                end
                ev = 1; eg = g; ec = g*N + c; lg = g; lc[g] = c;
            end
            if (prio_load) begin pr0 = prio_in[0]; pr1 = prio_in[1]; end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            compared++;
            if (gnt_valid !== 1'(ev)) begin
                mismatched++;
                $display("FAIL %s: gnt_valid=%b expected %0d", cur_req, gnt_valid, ev);
            end else if (ev == 1 && (gnt_grp !== 1'(eg) || gnt_chan !== GW'(ec))) begin
                mismatched++;
                $display("FAIL %s: grp/chan=%0d/%0d expected %0d/%0d", cur_req, gnt_grp, gnt_chan, eg, ec);
            end
        end
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic arb(input logic [2*N-1:0] r);
        @(negedge clk);
        req = r; arb_go = 1'b1;
        @(negedge clk);
        arb_go = 1'b0; req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        repeat (2) @(negedge clk);
        arb(8'b0001_0001);             // reset priorities: group 1 wins
        cur_req = "R2";
        arb(8'b0000_0100); arb(8'b0010_0000);
        cur_req = "R3";
        arb(8'b0000_0000); arb(8'b0000_0000);
        cur_req = "R4";
        arb(8'b1111_0000); arb(8'b0000_1111);
        cur_req = "R5";
        grp_rr_en = 0;
        arb(8'b0001_0001);
        cur_req = "R9";
        @(negedge clk); prio_load = 1; prio_in = 2'b01;
        @(negedge clk); prio_load = 0;
        arb(8'b0001_0001);             // group 0 now higher
        prio_load = 1; prio_in = 2'b11;
        @(negedge clk); prio_load = 0;
        cur_req = "R5";
        arb(8'b0001_0001);             // tie goes to group 1
        cur_req = "R6";
        grp_rr_en = 1;
        for (int i = 0; i < 4; i++) arb(8'b1000_1000);
        cur_req = "R7";
        grp_rr_en = 0; chan_rr_en = 0;
        arb(8'b0000_0110); arb(8'b0101_0000); arb(8'b1111_0000);
        cur_req = "R8";
        chan_rr_en = 1;
        for (int i = 0; i < 6; i++) arb(8'b1011_0000);
        arb(8'b0000_1111); arb(8'b0000_1111);
        cur_req = "R10";
        chan_rr_en = 0;
        arb(8'b1111_0000);
        chan_rr_en = 1;
        repeat (5) @(negedge clk);
        arb(8'b1111_0000);
        grp_rr_en = 1;
        arb(8'b0001_0001); arb(8'b0001_0001);
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req = 8'($urandom);
            arb_go = 1'($urandom);
            chan_rr_en = 1'($urandom);
            grp_rr_en = 1'($urandom);
            prio_load = (($urandom % 8) == 0);
            prio_in = 2'($urandom);
        end
        @(negedge clk);
        arb_go = 0; prio_load = 0; req = '0;
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule